// File: doc/BRIEF.md
# Serial-Loaded Banked Code Register File

This block is the digital front end of a multichannel 8-bit converter. A host sends 16-bit words over a three-wire link made of data, shift clock and load. Each word holds an 8-bit code and an 8-bit destination field. Each load commits the word into one of 36 channel registers. The 8-bit channel outputs stand in for the converter inputs.

Channels 1 to 30 hold one code each. Channels 31 to 36 each hold four codes, one per bank. Each bank has its own destination values. Two external bank-select pins choose which bank drives those six outputs. That choice is combinational, so it needs no reload. The serial output carries the oldest bit in the shift register, so several devices can share one data line in a chain.

All three link pins pass through a synchronizer into the system clock domain. A load-control state machine has three states:
- `LD_IDLE` moves to `LD_COMMIT` when the synchronized load is high.
- `LD_COMMIT` issues the single write pulse. It then moves to `LD_HOLD` if load is still high, or back to `LD_IDLE` if it is not.
- `LD_HOLD` returns to `LD_IDLE` once load is low.

Top module: `dacbank_top`

## Requirements
- R1: After reset, every channel output and the serial output are 0.
- R2: Frame bits are shifted in least significant bit first. The last 16 bits shifted before a load form the frame: bits 7:0 are the code and bits 15:8 are the destination value D.
- R3: A bit is shifted in only on a rising edge of the shift clock; a falling edge changes nothing. The serial output equals the bit shifted in 16 rising edges earlier, or 0 if fewer than 16 bits have been shifted since reset.
- R4: A load with D in 1..30 writes the code to channel D and leaves every other register unchanged.
- R5: A load with D in 31..54 writes banked register (bank (D-31)/6, channel 31+(D-31) mod 6).
- R6: A load with D equal to 0 or D above 54 changes no register.
- R7: Bank-select value 0, 1, 2 or 3 (pin 1 is the MSB) routes the bank with that number to channels 31..36. The change takes effect at once, with no load.
- R8: Each rising edge of load produces exactly one write, using the frame present at that moment. Frames shifted in while load stays high are not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_din | input | 1 | Serial data input |
| ser_load | input | 1 | Load strobe; its rising edge commits the frame |
| bank_sel | input | 2 | Bank selector for channels 31..36 |
| ser_dout | output | 1 | Cascade output, the oldest shift-register bit |
| ch_out | output | 288 | Channel codes; channel n occupies bits [(n-1)*8 +: 8] |

## Verification
The bench targets these corner cases:
- **Destination boundaries 0, 1, 30, 31, 36, 37, 54, 55 and 255.** An off-by-one in the decoder writes a neighbouring channel or bank, or writes when it should not.
- **A held load with a second frame shifted in underneath it.** A level-sensitive load would overwrite the first code.
- **Every bank-select value after each load.** A swapped pin order or a registered selector shows a stale or wrong bank.
- **The serial output after every shift-clock edge.** A first-in-at-wrong-end register shows here as a wrong cascade bit, and as mis-decoded frames.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;
    localparam int DEF_CODE_W   = 8;
    localparam int DEF_FRAME_W  = 16;
    localparam int DEF_N_PLAIN  = 30;
    localparam int DEF_N_BANKED = 6;
    localparam int DEF_N_BANKS  = 4;

    typedef enum logic [1:0] {
        LD_IDLE   = 2'd0,
        LD_COMMIT = 2'd1,
        LD_HOLD   = 2'd2
    } ld_state_t;
endpackage

// File: rtl/dacbank_sync.sv
module dacbank_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] pipe [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe[g] <= '0;
            end else if (g == 0) begin
                pipe[g] <= d;
            end else begin
                pipe[g] <= pipe[(g == 0) ? 0 : g - 1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/dacbank_shifter.sv
module dacbank_shifter #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_s,
    input  logic               din_s,
    output logic               shift_en,
    output logic [FRAME_W-1:0] frame,
    output logic               sdo
);
    logic               sclk_q;
    logic [FRAME_W-1:0] sr;

    assign shift_en = sclk_s & ~sclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            sr     <= '0;
        end else begin
            sclk_q <= sclk_s;
            if (shift_en) begin
                sr <= {sr[FRAME_W-2:0], din_s};
            end
        end
    end

    // Oldest bit sits at the top; frame bit k was the k-th bit received.
    for (genvar k = 0; k < FRAME_W; k++) begin : g_rev
        assign frame[k] = sr[FRAME_W-1-k];
    end

    assign sdo = sr[FRAME_W-1];
endmodule

// File: rtl/dacbank_ldctl.sv
module dacbank_ldctl
    import dacbank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ld_s,
    output logic wr_en
);
    ld_state_t state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= LD_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            LD_IDLE:   if (ld_s) nxt = LD_COMMIT;
            LD_COMMIT: nxt = ld_s ? LD_HOLD : LD_IDLE;
            LD_HOLD:   if (!ld_s) nxt = LD_IDLE;
            default:   nxt = LD_IDLE;
        endcase
    end

    always_comb begin
        wr_en = (state == LD_COMMIT);
    end
endmodule

// File: rtl/dacbank_regs.sv
module dacbank_regs #(
    parameter int CODE_W   = 8,
    parameter int ADDR_W   = 8,
    parameter int N_PLAIN  = 30,
    parameter int N_BANKED = 6,
    parameter int N_BANKS  = 4,
    parameter int BSEL_W   = 2
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic [CODE_W-1:0]                    code,
    input  logic [ADDR_W-1:0]                    dest,
    input  logic [BSEL_W-1:0]                    bank_sel,
    output logic [(N_PLAIN+N_BANKED)*CODE_W-1:0] ch_out
);
    logic [CODE_W-1:0] plain_q [N_PLAIN];
    logic [CODE_W-1:0] bank_q  [N_BANKS][N_BANKED];

    for (genvar p = 0; p < N_PLAIN; p++) begin : g_plain
        logic hit;
        assign hit = wr_en && (dest == ADDR_W'(p + 1));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                plain_q[p] <= '0;
            end else if (hit) begin
                plain_q[p] <= code;
            end
        end
        assign ch_out[p*CODE_W +: CODE_W] = plain_q[p];
    end

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        for (genvar c = 0; c < N_BANKED; c++) begin : g_ch
            logic hit;
            assign hit = wr_en && (dest == ADDR_W'(N_PLAIN + 1 + b*N_BANKED + c));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    bank_q[b][c] <= '0;
                end else if (hit) begin
                    bank_q[b][c] <= code;
                end
            end
        end
    end

    for (genvar c = 0; c < N_BANKED; c++) begin : g_mux
        assign ch_out[(N_PLAIN+c)*CODE_W +: CODE_W] = bank_q[bank_sel][c];
    end
endmodule

// File: rtl/dacbank_top.sv
module dacbank_top
    import dacbank_pkg::*;
#(
    parameter int CODE_W      = DEF_CODE_W,
    parameter int FRAME_W     = DEF_FRAME_W,
    parameter int N_PLAIN     = DEF_N_PLAIN,
    parameter int N_BANKED    = DEF_N_BANKED,
    parameter int N_BANKS     = DEF_N_BANKS,
    parameter int SYNC_STAGES = 2,
    localparam int BSEL_W     = $clog2(N_BANKS),
    localparam int N_CH       = N_PLAIN + N_BANKED
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ser_clk,
    input  logic                   ser_din,
    input  logic                   ser_load,
    input  logic [BSEL_W-1:0]      bank_sel,
    output logic                   ser_dout,
    output logic [N_CH*CODE_W-1:0] ch_out
);
    localparam int ADDR_W = FRAME_W - CODE_W;

    logic               sclk_s, din_s, ld_s;
    logic               shift_en, wr_en;
    logic [FRAME_W-1:0] frame;

    dacbank_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_clk, ser_din, ser_load}),
        .q     ({sclk_s, din_s, ld_s})
    );

    dacbank_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (sclk_s),
        .din_s    (din_s),
        .shift_en (shift_en),
        .frame    (frame),
        .sdo      (ser_dout)
    );

    dacbank_ldctl u_ldctl (
        .clk   (clk),
        .rst_n (rst_n),
        .ld_s  (ld_s),
        .wr_en (wr_en)
    );

    dacbank_regs #(
        .CODE_W   (CODE_W),
        .ADDR_W   (ADDR_W),
        .N_PLAIN  (N_PLAIN),
        .N_BANKED (N_BANKED),
        .N_BANKS  (N_BANKS),
        .BSEL_W   (BSEL_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .code     (frame[CODE_W-1:0]),
        .dest     (frame[FRAME_W-1:CODE_W]),
        .bank_sel (bank_sel),
        .ch_out   (ch_out)
    );
endmodule

// File: rtl/dacbank_chk.sv
module dacbank_chk #(
    parameter int OUT_W   = 288,
    parameter int PLAIN_W = 240,
    parameter int BSEL_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              shift_en,
    input logic              wr_en,
    input logic              ld_s,
    input logic              sdo,
    input logic [BSEL_W-1:0] bank_sel,
    input logic [OUT_W-1:0]  ch_out
);
    // R3
    sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(sdo));

    // R8
    single_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R8
    wr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(ld_s));

    // R4
    plain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ch_out[PLAIN_W-1:0]));

    // R7
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en) && $stable(bank_sel)) |-> $stable(ch_out[OUT_W-1:PLAIN_W]));
endmodule

bind dacbank_top dacbank_chk #(
    .OUT_W   (N_CH*CODE_W),
    .PLAIN_W (N_PLAIN*CODE_W),
    .BSEL_W  (BSEL_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .wr_en    (wr_en),
    .ld_s     (ld_s),
    .sdo      (ser_dout),
    .bank_sel (bank_sel),
    .ch_out   (ch_out)
);

// File: tb/sim_dacbank_top.sv
`timescale 1ns/1ps
module sim_dacbank_top;
    localparam int NP = 30;
    localparam int NB = 6;
    localparam int NK = 4;
    localparam int NC = NP + NB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ser_clk = 1'b0;
    logic          ser_din = 1'b0;
    logic          ser_load = 1'b0;
    logic [1:0]    bank_sel = 2'd0;
    logic          ser_dout;
    logic [NC*8-1:0] ch_out;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    int exp_plain [NP];
    int exp_bank [NK][NB];
    bit hist [$];

    always #5 clk = ~clk;

    dacbank_top u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_clk  (ser_clk),
        .ser_din  (ser_din),
        .ser_load (ser_load),
        .bank_sel (bank_sel),
        .ser_dout (ser_dout),
        .ch_out   (ch_out)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
        end
    endtask

    function automatic bit exp_sdo();
        return (hist.size() == 16) ? hist[0] : 1'b0;
    endfunction

    task automatic shift_bit(input bit b);
        @(negedge clk);
        ser_din = b;
        ser_clk = 1'b0;
        repeat (5) @(negedge clk);
        chk(ser_dout == exp_sdo(), "R3 falling edge sdo", ser_dout, exp_sdo());
        ser_clk = 1'b1;
        hist.push_back(b);
        if (hist.size() > 16) void'(hist.pop_front());
        repeat (5) @(negedge clk);
        chk(ser_dout == exp_sdo(), "R3 rising edge sdo", ser_dout, exp_sdo());
        ser_clk = 1'b0;
    endtask

    task automatic send_frame(input int dest, input int code);
        logic [15:0] w;
        w = {dest[7:0], code[7:0]};
        for (int k = 0; k < 16; k++) shift_bit(w[k]);
        @(negedge clk);
        ser_clk = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    // Model of one commit: frame bit k is the k-th of the last 16 bits (R2).
    task automatic model_commit();
        int d;
        int c;
        d = 0;
        c = 0;
        for (int k = 0; k < 8; k++) c |= int'(hist[k]) << k;
        for (int k = 0; k < 8; k++) d |= int'(hist[k+8]) << k;
        if (d >= 1 && d <= NP) exp_plain[d-1] = c;
        else if (d > NP && d <= NP + NK*NB) exp_bank[(d-NP-1)/NB][(d-NP-1)%NB] = c;
    endtask

    task automatic pulse_load();
        @(negedge clk);
        ser_load = 1'b1;
        model_commit();
        repeat (3) @(negedge clk);
        ser_load = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic check_outs(input string tag);
        logic [1:0] keep;
        keep = bank_sel;
        for (int s = 0; s < NK; s++) begin
            @(negedge clk);
            bank_sel = 2'(s);
            #1;
            for (int ch = 0; ch < NC; ch++) begin
                int e;
                int a;
                e = (ch < NP) ? exp_plain[ch] : exp_bank[s][ch-NP];
                a = int'(ch_out[ch*8 +: 8]);
                chk(a == e, $sformatf("%s sel=%0d ch%0d", tag, s, ch + 1), a, e);
            end
        end
        @(negedge clk);
        bank_sel = keep;
    endtask

    task automatic write_chk(input int dest, input int code, input string tag);
        send_frame(dest, code);
        pulse_load();
        check_outs(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NP; i++) exp_plain[i] = 0;
        for (int b = 0; b < NK; b++)
            for (int c = 0; c < NB; c++) exp_bank[b][c] = 0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(ser_dout == 1'b0, "R1 reset sdo", ser_dout, 0);
        check_outs("R1 reset");

        // Decoder boundaries and bit order
        write_chk(1, 8'h11, "R2 R4 dest1");
        write_chk(30, 8'hE7, "R4 dest30");
        write_chk(31, 8'h31, "R5 dest31");
        write_chk(36, 8'h36, "R5 dest36");
        write_chk(37, 8'h41, "R5 dest37");
        write_chk(54, 8'hC9, "R5 dest54");
        write_chk(44, 8'h82, "R5 R7 dest44");

        // Ignored destinations
        write_chk(0, 8'hAA, "R6 dest0");
        write_chk(55, 8'hAB, "R6 dest55");
        write_chk(255, 8'hAC, "R6 dest255");

        // Held load: second frame under a high load is not written
        send_frame(5, 8'h5A);
        @(negedge clk);
        ser_load = 1'b1;
        model_commit();
        repeat (8) @(negedge clk);
        send_frame(5, 8'h77);
        @(negedge clk);
        ser_load = 1'b0;
        repeat (6) @(negedge clk);
        check_outs("R8 held load");
        pulse_load();
        check_outs("R8 next load");

        // Random frames
        for (int n = 0; n < 40; n++) begin
            int d;
            int c;
            d = int'($urandom_range(0, 60));
            c = int'($urandom_range(0, 255));
            send_frame(d, c);
            pulse_load();
            if (n % 8 == 7) check_outs("R2 R4 R5 R6 R7 random");
        end
        check_outs("R7 final");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule